// File: doc/BRIEF.md
# Aligned Interrupt Vector Block Allocator

This block hands out groups of interrupt vectors from a pool of up to 64. A requester asks for a group of 2^k vectors, where k is the 3-bit size exponent a device advertises for multi-message interrupts. The allocator searches for a group that starts on a multiple of its own size and whose vectors are all unused. It marks those vectors as taken and returns the first vector of the group, or it reports failure when no such group fits. A separate release port gives vectors back. The caller names the first vector and the number of vectors to free.

The usable pool is either the lower half of the vectors or all of them, chosen by a configuration input. The search looks at one candidate start per clock. While it runs, the request side is not ready. A release that arrives during a search takes effect before the candidate of that same cycle is judged, so freed vectors can be granted at once.

Top module: `vec_block_alloc`

## Requirements
- R1: After reset no vector is allocated, `req_ready` is 1 and `rsp_valid` is 0.
- R2: A request with exponent k asks for 2^k vectors. A granted `rsp_base` is always a multiple of 2^k.
- R3: Candidate starts are tried in rising order 0, 2^k, 2·2^k, and so on. The first candidate whose whole group is unused is granted.
- R4: A group must lie entirely below the vector limit, which is 32 when `cfg_wide` is 0 and 64 when it is 1. When no candidate up to that limit is free, the response has `rsp_fail`=1 and `rsp_base`=0.
- R5: A grant marks every vector of the group as used. No later grant overlaps it until it is released.
- R6: An exponent above 5, or a group larger than the vector limit, is refused with `rsp_fail`=1 one cycle after acceptance. The pool is left unchanged.
- R7: A release with `rel_valid`=1 frees `rel_count` vectors starting at `rel_base`. A count of 0 frees nothing.
- R8: A release in the same cycle as a search step is applied before that step is judged.
- R9: The search takes one candidate per cycle and `req_ready` is 0 while it runs. Counting clock edges from the accepting edge, the single one-cycle response appears i+1 edges later for a grant at candidate index i. A failed search of L candidates answers L edges later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_wide | input | 1 | Vector limit select: 0 = 32, 1 = 64 |
| req_valid | input | 1 | Request present |
| req_mme | input | 3 | Size exponent k of the request |
| req_ready | output | 1 | Allocator idle and able to accept |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_base | output | 6 | First vector of the granted group |
| rsp_fail | output | 1 | Request could not be granted |
| rel_valid | input | 1 | Release strobe |
| rel_base | input | 6 | First vector to free |
| rel_count | input | 7 | Number of vectors to free |

## Verification
The hardest case to reach is a release that lands in exactly the cycle where the search is judging the group it frees. The bench fills the narrow pool with one 32-vector group. It then issues a second 32-vector request and raises the release of the first group on the edge right after acceptance. A grant of base 0 on the first candidate is the only correct answer. Long searches and late failures in the wide pool come from random requests and releases against a fragmented pool, with toggles of the limit in between.

// File: rtl/vba_pkg.sv
// Package: shared types of the vector block allocator.
// Assumes nothing beyond a standard SystemVerilog compiler.
package vba_pkg;

    // Search engine states.
    typedef enum logic {
        ST_IDLE   = 1'b0,
        ST_SEARCH = 1'b1
    } vba_state_e;

endpackage

// File: rtl/vba_window.sv
// Module: vba_window
// Builds a vector mask with COUNT ones starting at bit BASE. Bits that would
// fall at or above NV are dropped. Assumes BASE < NV.
module vba_window #(
    parameter int NV = 64,
    localparam int BW = $clog2(NV),
    localparam int CW = BW + 1
) (
    input  logic [BW-1:0] base,
    input  logic [CW-1:0] count,
    output logic [NV-1:0] mask
);
    logic [CW:0] lo;
    logic [CW:0] hi;

    // Window bounds, widened so the sum cannot wrap.
    always_comb begin
        lo = {2'b00, base};
        hi = {2'b00, base} + {1'b0, count};
    end

    // One comparator pair per vector bit.
    for (genvar i = 0; i < NV; i++) begin : g_bit
        localparam logic [CW:0] IDX = i;
        assign mask[i] = (IDX >= lo) && (IDX < hi);
    end
endmodule

// File: rtl/vba_bitmap.sv
// Module: vba_bitmap
// Holds the occupancy bitmap. A release clears its mask first, then a grant
// sets its mask. The post-release view is exported so the search judges
// candidates against it. Assumes the grant mask is free in that view.
module vba_bitmap #(
    parameter int NV = 64
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [NV-1:0] rel_mask,
    input  logic          set_en,
    input  logic [NV-1:0] set_mask,
    output logic [NV-1:0] occ_rel
);
    logic [NV-1:0] occ_q;

    // Bitmap as seen after this cycle's release.
    always_comb occ_rel = occ_q & ~rel_mask;

    // Bitmap register: release, then grant.
    always_ff @(posedge clk) begin
        if (!rst_n) occ_q <= '0;
        else        occ_q <= occ_rel | (set_en ? set_mask : '0);
    end

    // R5: a grant may only claim vectors that are free after the release.
    a_r5_grant_on_free: assert property (@(posedge clk) disable iff (!rst_n)
        set_en |-> ((occ_rel & set_mask) == '0));

    // R5: granted vectors read as used one cycle later.
    a_r5_window_set: assert property (@(posedge clk) disable iff (!rst_n)
        set_en |=> ((occ_q & $past(set_mask)) == $past(set_mask)));

    // R7: released vectors read as free when no grant is made.
    a_r7_release_clears: assert property (@(posedge clk) disable iff (!rst_n)
        ((rel_mask != '0) && !set_en) |=> ((occ_q & $past(rel_mask)) == '0));
endmodule

// File: rtl/vba_search.sv
// Module: vba_search
// Accepts a request and checks size limits. It then steps one aligned
// candidate per cycle until a free group is found or the limit is reached.
// Assumes cfg_wide is stable while a search runs.
module vba_search
    import vba_pkg::*;
#(
    parameter int NV      = 64,
    parameter int MW      = 3,
    parameter int MME_MAX = 5,
    localparam int BW = $clog2(NV),
    localparam int CW = BW + 1,
    localparam int XW = CW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_wide,
    input  logic          req_valid,
    input  logic [MW-1:0] req_mme,
    output logic          req_ready,
    input  logic [NV-1:0] occ_rel,
    input  logic [NV-1:0] win_mask,
    output logic [BW-1:0] cand_base,
    output logic [CW-1:0] cand_count,
    output logic          set_en,
    output logic          rsp_valid,
    output logic [BW-1:0] rsp_base,
    output logic          rsp_fail
);
    localparam logic [XW-1:0] LIM_WIDE   = XW'(NV);
    localparam logic [XW-1:0] LIM_NARROW = XW'(NV / 2);
    localparam logic [XW-1:0] ONE_X      = XW'(1);

    vba_state_e    state_q;
    logic [MW-1:0] mme_q;
    logic [CW-1:0] cand_q;
    logic [XW-1:0] limit;
    logic [XW-1:0] size_cur;
    logic [XW-1:0] req_size;
    logic [XW-1:0] next_x;
    logic [XW-1:0] end_x;
    logic          free;
    logic          req_bad;
    logic          accept;

    // Sizes, limit and the next-candidate arithmetic.
    always_comb begin
        limit    = cfg_wide ? LIM_WIDE : LIM_NARROW;
        size_cur = ONE_X << mme_q;
        req_size = ONE_X << req_mme;
        req_bad  = (req_mme > MW'(MME_MAX)) || (req_size > limit);
        next_x   = {1'b0, cand_q} + size_cur;
        end_x    = next_x + size_cur;
        free     = ((occ_rel & win_mask) == '0);
    end

    // Handshake, window drive and grant strobe.
    always_comb begin
        req_ready  = (state_q == ST_IDLE);
        accept     = req_valid && req_ready;
        cand_base  = cand_q[BW-1:0];
        cand_count = size_cur[CW-1:0];
        set_en     = (state_q == ST_SEARCH) && free;
    end

    // Search state, candidate pointer and registered response.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= ST_IDLE;
            mme_q     <= '0;
            cand_q    <= '0;
            rsp_valid <= 1'b0;
            rsp_base  <= '0;
            rsp_fail  <= 1'b0;
        end else begin
            rsp_valid <= 1'b0;
            unique case (state_q)
                ST_IDLE: begin
                    if (accept) begin
                        if (req_bad) begin
                            rsp_valid <= 1'b1;
                            rsp_fail  <= 1'b1;
                            rsp_base  <= '0;
                        end else begin
                            mme_q   <= req_mme;
                            cand_q  <= '0;
                            state_q <= ST_SEARCH;
                        end
                    end
                end
                ST_SEARCH: begin
                    if (free) begin
                        rsp_valid <= 1'b1;
                        rsp_fail  <= 1'b0;
                        rsp_base  <= cand_q[BW-1:0];
                        state_q   <= ST_IDLE;
                    end else if (end_x > limit) begin
                        rsp_valid <= 1'b1;
                        rsp_fail  <= 1'b1;
                        rsp_base  <= '0;
                        state_q   <= ST_IDLE;
                    end else begin
                        cand_q <= next_x[CW-1:0];
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // R2: a granted base is aligned to the block size.
    a_r2_aligned: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_fail) |-> (({2'b00, rsp_base} & (size_cur - ONE_X)) == '0));

    // R4: a granted group ends at or below the vector limit.
    a_r4_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_fail) |-> (({2'b00, rsp_base} + size_cur) <= limit));

    // R9: after acceptance the block is busy unless it answered at once.
    a_r9_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> (!req_ready || rsp_valid));

    // R6: a refused request never grants anything.
    a_r6_refuse_no_grant: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && req_bad) |=> (rsp_valid && rsp_fail));
endmodule

// File: rtl/vec_block_alloc.sv
// Module: vec_block_alloc (top)
// Aligned block allocator for interrupt vectors. It ties the search engine to
// the occupancy bitmap through two window generators, one for releases and
// one for the candidate under test. Assumes releases name vectors below NV.
module vec_block_alloc #(
    parameter int NV      = 64,
    parameter int MW      = 3,
    parameter int MME_MAX = 5,
    localparam int BW = $clog2(NV),
    localparam int CW = BW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_wide,
    input  logic          req_valid,
    input  logic [MW-1:0] req_mme,
    output logic          req_ready,
    output logic          rsp_valid,
    output logic [BW-1:0] rsp_base,
    output logic          rsp_fail,
    input  logic          rel_valid,
    input  logic [BW-1:0] rel_base,
    input  logic [CW-1:0] rel_count
);
    logic [CW-1:0] rel_cnt_eff;
    logic [NV-1:0] rel_mask;
    logic [NV-1:0] win_mask;
    logic [NV-1:0] occ_rel;
    logic [BW-1:0] cand_base;
    logic [CW-1:0] cand_count;
    logic          set_en;

    // A release without its strobe frees nothing.
    always_comb rel_cnt_eff = rel_valid ? rel_count : '0;

    vba_window #(.NV(NV)) u_rel_win (
        .base (rel_base),
        .count(rel_cnt_eff),
        .mask (rel_mask)
    );

    vba_window #(.NV(NV)) u_cand_win (
        .base (cand_base),
        .count(cand_count),
        .mask (win_mask)
    );

    vba_bitmap #(.NV(NV)) u_bitmap (
        .clk     (clk),
        .rst_n   (rst_n),
        .rel_mask(rel_mask),
        .set_en  (set_en),
        .set_mask(win_mask),
        .occ_rel (occ_rel)
    );

    vba_search #(.NV(NV), .MW(MW), .MME_MAX(MME_MAX)) u_search (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_wide  (cfg_wide),
        .req_valid (req_valid),
        .req_mme   (req_mme),
        .req_ready (req_ready),
        .occ_rel   (occ_rel),
        .win_mask  (win_mask),
        .cand_base (cand_base),
        .cand_count(cand_count),
        .set_en    (set_en),
        .rsp_valid (rsp_valid),
        .rsp_base  (rsp_base),
        .rsp_fail  (rsp_fail)
    );

    // R1: the outputs are quiet in the cycle after reset.
    a_r1_reset_quiet: assert property (@(posedge clk)
        !rst_n |=> (req_ready && !rsp_valid));
endmodule

// File: tb/vec_block_alloc_tb.sv
// Bench: directed corner cases plus seeded random traffic against a model.
module vec_block_alloc_tb;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_wide = 1'b0;
    logic       req_valid = 1'b0;
    logic [2:0] req_mme = '0;
    logic       req_ready;
    logic       rsp_valid;
    logic [5:0] rsp_base;
    logic       rsp_fail;
    logic       rel_valid = 1'b0;
    logic [5:0] rel_base = '0;
    logic [6:0] rel_count = '0;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    logic [63:0] m_occ = '0;
    int a_base[64];
    int a_size[64];
    int n_a = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    vec_block_alloc u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_wide(cfg_wide),
        .req_valid(req_valid), .req_mme(req_mme), .req_ready(req_ready),
        .rsp_valid(rsp_valid), .rsp_base(rsp_base), .rsp_fail(rsp_fail),
        .rel_valid(rel_valid), .rel_base(rel_base), .rel_count(rel_count)
    );

    function automatic logic [63:0] wmask(input int b, input int sz);
        return ((64'd1 << sz) - 64'd1) << b;
    endfunction

    // Expected grant, failure flag and edge latency from the requirements.
    function automatic void ref_search(input int mme, input bit wide, input logic [63:0] occ,
                                       output int base, output bit fail, output int lat);
        int lim;
        int sz;
        lim = wide ? 64 : 32;
        base = 0; fail = 1'b1; lat = 1;
        if (mme > 5 || (1 << mme) > lim) return;
        sz = 1 << mme;
        lat = 0;
        for (int b = 0; b + sz <= lim; b += sz) begin
            lat++;
            if ((occ & wmask(b, sz)) == 64'd0) begin
                base = b; fail = 1'b0; lat = lat + 1;
                return;
            end
        end
        lat = lat + 1;
    endfunction

    task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic do_req(input int mme, input string req);
        int eb; bit ef; int el; int n;
        ref_search(mme, cfg_wide, m_occ, eb, ef, el);
        @(negedge clk);
        req_valid = 1'b1; req_mme = 3'(mme);
        @(posedge clk);
        n = 0;
        do begin
            @(negedge clk);
            req_valid = 1'b0;
            n++;
        end while (!rsp_valid && n < 200);
        check(rsp_fail == ef, req, "fail flag", int'(rsp_fail), int'(ef));
        if (!ef) check(int'(rsp_base) == eb, req, "base", int'(rsp_base), eb);
        check(n == el, "R9", "response latency", n, el);
        if (!ef) begin
            m_occ |= wmask(eb, 1 << mme);
            a_base[n_a] = eb; a_size[n_a] = 1 << mme; n_a++;
        end
        @(negedge clk);
        check(!rsp_valid, "R9", "single response cycle", int'(rsp_valid), 0);
    endtask

    task automatic do_rel(input int b, input int c);
        @(negedge clk);
        rel_valid = 1'b1; rel_base = 6'(b); rel_count = 7'(c);
        @(negedge clk);
        rel_valid = 1'b0;
        m_occ &= ~wmask(b, c);
    endtask

    task automatic clear_all();
        do_rel(0, 64);
        n_a = 0;
    endtask

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        int k; int r; int eb; bit ef; int el; int n;
        void'($urandom(32'd1234));
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        @(negedge clk);
        check(req_ready, "R1", "ready after reset", int'(req_ready), 1);
        check(!rsp_valid, "R1", "no response after reset", int'(rsp_valid), 0);

        // R1: empty pool grants the whole upper limit at base 0.
        cfg_wide = 1'b1;
        do_req(5, "R1");
        clear_all();

        // R3: lowest free single vectors, then R2: aligned pair skips ahead.
        cfg_wide = 1'b0;
        do_req(0, "R3"); do_req(0, "R3"); do_req(0, "R3");
        do_req(1, "R2");
        // R6: oversized exponents are refused at once.
        do_req(6, "R6"); do_req(7, "R6");
        // R4: narrow limit has one 32-group candidate, taken -> fail; wide finds 32.
        do_req(5, "R4");
        cfg_wide = 1'b1;
        do_req(5, "R4");
        cfg_wide = 1'b0;
        // R7: zero-count release frees nothing, one-vector release frees vector 0.
        do_rel(0, 0);
        do_req(0, "R7");
        do_rel(0, 1);
        do_req(0, "R7");
        // R5: a new group avoids every granted vector.
        do_req(2, "R5");
        clear_all();

        // R8: release of the only group in the same cycle as the first candidate.
        cfg_wide = 1'b0;
        do_req(5, "R8");
        @(negedge clk);
        req_valid = 1'b1; req_mme = 3'd5;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        rel_valid = 1'b1; rel_base = 6'd0; rel_count = 7'd32;
        n = 1;
        @(posedge clk);
        @(negedge clk);
        rel_valid = 1'b0;
        n++;
        check(rsp_valid && !rsp_fail, "R8", "grant with same-cycle release", int'(rsp_fail), 0);
        check(rsp_base == 6'd0, "R8", "base", int'(rsp_base), 0);
        check(n == 2, "R8", "latency", n, 2);
        m_occ = wmask(0, 32);
        n_a = 0;
        clear_all();

        // Random traffic against the model.
        for (int it = 0; it < 400; it++) begin
            r = int'($urandom % 10);
            if (r == 0) begin
                cfg_wide = ~cfg_wide;
            end else if (r < 4 && n_a > 0) begin
                k = int'($urandom % n_a);
                do_rel(a_base[k], a_size[k]);
                a_base[k] = a_base[n_a - 1]; a_size[k] = a_size[n_a - 1]; n_a--;
            end else begin
                k = ($urandom % 4 == 0) ? int'($urandom % 8) : int'($urandom % 4);
                do_req(k, "R5");
            end
        end

        // R4: final wide-pool exhaustion check via the model.
        clear_all();
        cfg_wide = 1'b1;
        for (int i = 0; i < 8; i++) do_req(3, "R4");
        ref_search(0, 1'b1, m_occ, eb, ef, el);
        check(ef, "R4", "model full pool", int'(ef), 1);
        do_req(0, "R4");

        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule